// File: doc/BRIEF.md
# General-Purpose I/O Port Register Bank

This block is one 8-bit bidirectional general-purpose I/O port with a small synchronous register bus. Software sets a direction mask, an output data latch, a per-pin analog-input select and per-pin pull-up enables, plus a global pull-up disable. For each pin the block drives output data, an output enable and a pull-up request toward the pad models, and takes the pad levels back.

The port address is asymmetric. A write to it lands in the output latch, and a read from it returns the live, synchronized pin levels. The latch address reads back what was stored. A pin in analog mode reads as 0 on the digital side but can still drive its latch value when its direction says output. A pull-up is requested only on an input pin, and only while the global disable is clear.

The bus has no handshake and no back-pressure. A write strobe with address and data is taken on the rising clock edge in the cycle it is asserted. Read data is combinational from the address in the same cycle, and every access completes at once.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset the direction register reads 0xFF, the latch 0x00, the analog-select register 0x3F, the pull-up enables 0xFF and the control register 0x01. All `pin_oe` and `pin_pu` bits are 0.
- R2: Address 1 is the direction register. A stored bit of 1 makes the pin an input, so `pin_oe` is 0 for that bit. A 0 bit drives the pin, so `pin_oe` is 1.
- R3: A write to address 0 (port) or to address 2 (latch) loads the latch in the next cycle. `pin_out` always equals the latch, and a read of address 2 returns it.
- R4: A read of address 0 returns the pin levels of `pin_in` through a two-flop synchronizer. A change becomes visible after exactly two rising edges, and the latch contents never appear there.
- R5: Where an analog-select bit is 1, the matching bit of a port read is 0 whatever the pin level. Bits 7:6 have no analog select and always show the pin.
- R6: Address 3 holds the analog select in bits 5:0 only. Bits 7:6 always read 0 and writes to them are dropped.
- R7: Analog select has no effect on `pin_out` or `pin_oe`.
- R8: Address 4 holds the per-pin pull-up enables, and bit 0 of address 5 is the global pull-up disable. `pin_pu` equals enable AND direction AND NOT disable, bit by bit.
- R9: Addresses 6 and 7 read 0, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, taken on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 8 | Levels sampled from the pads |
| pin_out | output | 8 | Output data toward the pads |
| pin_oe | output | 8 | Per-pin output-driver enable |
| pin_pu | output | 8 | Per-pin weak pull-up request |

## Verification
The bench sweeps every direction value with the global disable both set and clear, and with two enable patterns. This separates the direction, enable and global terms of the pull-up rule, and the driver-enable inversion. It walks every latch value through both writable addresses, alternating between them, so a latch fed by only one of the two addresses is caught. It tries every analog-select value against an all-ones pin pattern and an alternating one. That tells input gating apart from output gating, and the upper ungated bits apart from the lower ones. A pin step read one and two edges later pins down the synchronizer depth, and writes to the unused addresses show that they alias nothing.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    GA_PORT = 3'd0,
    GA_DIR  = 3'd1,
    GA_LAT  = 3'd2,
    GA_ANA  = 3'd3,
    GA_PULL = 3'd4,
    GA_CTRL = 3'd5
  } gpio_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= d;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W        = 8,
  parameter int ANA_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      lat_q,
  output logic [W-1:0]      ana_q,
  output logic [W-1:0]      pull_q,
  output logic              pu_off_q
);
  localparam int PAD_BITS = W - ANA_BITS;

  logic [ANA_BITS-1:0] ana_r;
  logic wr_port, wr_dir, wr_lat, wr_ana, wr_pull, wr_ctrl;

  always_comb begin
    wr_port = wr && (addr == GA_PORT);
    wr_dir  = wr && (addr == GA_DIR);
    wr_lat  = wr && (addr == GA_LAT);
    wr_ana  = wr && (addr == GA_ANA);
    wr_pull = wr && (addr == GA_PULL);
    wr_ctrl = wr && (addr == GA_CTRL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '1;
      lat_q    <= '0;
      ana_r    <= '1;
      pull_q   <= '1;
      pu_off_q <= 1'b1;
    end else begin
      if (wr_dir)            dir_q    <= wdata;
      if (wr_port || wr_lat) lat_q    <= wdata;
      if (wr_ana)            ana_r    <= wdata[ANA_BITS-1:0];
      if (wr_pull)           pull_q   <= wdata;
      if (wr_ctrl)           pu_off_q <= wdata[0];
    end
  end

  assign ana_q = {{PAD_BITS{1'b0}}, ana_r};
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int W = 8
) (
  input  logic [W-1:0] dir,
  input  logic [W-1:0] lat,
  input  logic [W-1:0] ana,
  input  logic [W-1:0] pull,
  input  logic         pu_off,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] dig_in
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      // output path ignores analog select
      assign pad_out[i] = lat[i];
      assign pad_oe[i]  = ~dir[i];
      // pull-up only on an input pin with global disable clear
      assign pad_pu[i]  = pull[i] & dir[i] & ~pu_off;
      // analog pins read as zero on the digital side
      assign dig_in[i]  = pin_sync[i] & ~ana[i];
    end
  endgenerate
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      dig_in,
  input  logic [W-1:0]      dir,
  input  logic [W-1:0]      lat,
  input  logic [W-1:0]      ana,
  input  logic [W-1:0]      pull,
  input  logic              pu_off,
  output logic [W-1:0]      rdata
);
  always_comb begin
    unique case (addr)
      GA_PORT: rdata = dig_in;
      GA_DIR:  rdata = dir;
      GA_LAT:  rdata = lat;
      GA_ANA:  rdata = ana;
      GA_PULL: rdata = pull;
      GA_CTRL: rdata = {{(W-1){1'b0}}, pu_off};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int DATA_W      = 8,
  parameter int ANA_BITS    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe,
  output logic [DATA_W-1:0] pin_pu
);
  logic [DATA_W-1:0] dir_q, lat_q, ana_q, pull_q, sync_q, dig_in;
  logic              pu_off_q;

  gpio_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
  );

  gpio_regs #(.W(DATA_W), .ANA_BITS(ANA_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .dir_q(dir_q), .lat_q(lat_q), .ana_q(ana_q),
    .pull_q(pull_q), .pu_off_q(pu_off_q)
  );

  gpio_pad_ctrl #(.W(DATA_W)) u_pad (
    .dir(dir_q), .lat(lat_q), .ana(ana_q), .pull(pull_q),
    .pu_off(pu_off_q), .pin_sync(sync_q), .pad_out(pin_out),
    .pad_oe(pin_oe), .pad_pu(pin_pu), .dig_in(dig_in)
  );

  gpio_rdmux #(.W(DATA_W)) u_rd (
    .addr(bus_addr), .dig_in(dig_in), .dir(dir_q), .lat(lat_q),
    .ana(ana_q), .pull(pull_q), .pu_off(pu_off_q), .rdata(bus_rdata)
  );
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   bus_addr,
  input logic         bus_wr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pin_in,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] pin_pu
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  p_reset_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd0) |-> (pin_oe == '0 && pin_pu == '0));

  p_dir_to_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1) |=> (pin_oe == ~$past(bus_wdata)));

  p_latch_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd2)) |=> (pin_out == $past(bus_wdata)));

  p_sync_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd0 && age_q >= 2'd2) |-> (bus_rdata[W-1:W-2] == $past(pin_in[W-1:W-2], 2)));

  p_ana_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd3) |-> (bus_rdata[W-1:W-2] == 2'b00));

  p_pullup_input_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0);

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= 3'd6) |-> (bus_rdata == '0));

  p_unmapped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr >= 3'd6) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_pu)));
endmodule

bind gpio_port_bank gpio_port_bank_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
);

// File: tb/gpio_port_bank_bench.sv
module gpio_port_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe, pin_pu;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_bank u_gpio_port_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // drive at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle_pins(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rv, exp_pu, wpu;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(3'd1, rv); chk("R1 dir reset", rv, 8'hFF);
    rd(3'd2, rv); chk("R1 latch reset", rv, 8'h00);
    rd(3'd3, rv); chk("R1 analog reset", rv, 8'h3F);
    rd(3'd4, rv); chk("R1 pullup reset", rv, 8'hFF);
    rd(3'd5, rv); chk("R1 ctrl reset", rv, 8'h01);
    chk("R1 oe reset", pin_oe, 8'h00);
    chk("R1 pu reset", pin_pu, 8'h00);

    // R2 and R8 sweep: every direction, both global states, two enable masks
    for (int m = 0; m < 2; m++) begin
      wpu = (m == 0) ? 8'hFF : 8'h5A;
      wr(3'd4, wpu);
      for (int g = 0; g < 2; g++) begin
        wr(3'd5, 8'(g));
        for (int d = 0; d < 256; d++) begin
          wr(3'd1, 8'(d));
          exp_pu = wpu & 8'(d) & {8{g == 0}};
          chk("R2 oe vs direction", pin_oe, ~8'(d));
          chk("R8 pull-up qualify", pin_pu, exp_pu);
        end
      end
    end
    wr(3'd5, 8'h01);

    // R3 latch via port and latch addresses, alternating
    for (int v = 0; v < 256; v++) begin
      wr((v % 2 == 0) ? 3'd0 : 3'd2, 8'(v ^ 8'hC3));
      chk("R3 pin_out", pin_out, 8'(v ^ 8'hC3));
      rd(3'd2, rv); chk("R3 latch readback", rv, 8'(v ^ 8'hC3));
    end

    // R4 port reads show pins, not latch, after two edges
    wr(3'd3, 8'h00);
    wr(3'd2, 8'hFF);
    settle_pins(8'h00);
    rd(3'd0, rv); chk("R4 port not latch", rv, 8'h00);
    @(negedge clk);
    pin_in = 8'h3C;
    @(negedge clk);
    rd(3'd0, rv); chk("R4 one edge still old", rv, 8'h00);
    @(negedge clk);
    rd(3'd0, rv); chk("R4 two edges new", rv, 8'h3C);

    // R5, R6, R7 analog sweep
    wr(3'd1, 8'h00);
    for (int p = 0; p < 2; p++) begin
      settle_pins((p == 0) ? 8'hFF : 8'hA5);
      for (int a = 0; a < 64; a++) begin
        wr(3'd3, 8'(a) | 8'hC0);
        rd(3'd3, rv); chk("R6 analog readback", rv, 8'(a));
        rd(3'd0, rv);
        chk("R5 analog gating", rv, ((p == 0) ? 8'hFF : 8'hA5) & ~8'(a));
        chk("R7 oe untouched", pin_oe, 8'hFF);
        chk("R7 out untouched", pin_out, 8'hFF);
      end
    end

    // R9 unmapped addresses
    wr(3'd1, 8'h0F); wr(3'd2, 8'h96); wr(3'd3, 8'h12);
    wr(3'd4, 8'h33); wr(3'd5, 8'h00);
    wr(3'd6, 8'h5A); wr(3'd7, 8'hA5);
    rd(3'd6, rv); chk("R9 addr6 reads 0", rv, 8'h00);
    rd(3'd7, rv); chk("R9 addr7 reads 0", rv, 8'h00);
    rd(3'd1, rv); chk("R9 dir kept", rv, 8'h0F);
    rd(3'd2, rv); chk("R9 latch kept", rv, 8'h96);
    rd(3'd3, rv); chk("R9 analog kept", rv, 8'h12);
    rd(3'd4, rv); chk("R9 pullup kept", rv, 8'h33);
    rd(3'd5, rv); chk("R9 ctrl kept", rv, 8'h00);
    chk("R9 pu output kept", pin_pu, 8'h33 & 8'h0F);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule